// File: doc/BRIEF.md
# Single Bus Cycle Generator

This block stands in for a processor in its socket on a target board and runs one complete bus transaction of the classic eight-bit request/strobe style. The host side loads the address, the write data, the transfer direction and the address space (memory or I/O), plus a refresh option, and then pulses a start input. The block hands that request across to the clock that feeds the socket. It runs the T-states on both edges of that clock, honours the wait input, captures read data, and then releases every pin. Completion and any read value come back to the host with a one-cycle done pulse.

All socket-side timing comes from the target clock and not from the host clock. The two domains exchange one toggle each way through a synchroniser chain of configurable depth. The request fields stay frozen while a transaction is in flight, so they can cross without their own synchronisers. A build option removes the refresh hardware entirely.

Top module: `bus_cycle_gen`

## Requirements
- R1: While reset is asserted and after it is released, all active-low strobes (mreq, iorq, rd, wr, rfsh) read 1, both output enables read 0, and host_busy and host_done read 0.
- R2: One accepted start pulse produces exactly one transaction on the socket. A start pulse that arrives while host_busy is 1 is ignored and does not alter the running transaction.
- R3: In a memory transaction the address enable rises at the rising edge that begins T1. The address holds the loaded value through T3. mreq_n is low from the falling edge of T1 to the falling edge of T3. On reads rd_n has the same window. On writes wr_n is low from the falling edge of T2 to the falling edge of T3. iorq_n stays 1.
- R4: An I/O transaction always contains at least one wait state after T2. iorq_n, together with rd_n (read) or wr_n (write), is low from the rising edge of T2 to the falling edge of T3. mreq_n stays 1 outside a refresh phase.
- R5: The wait input is sampled on the falling edge of T2 and on the falling edge of every wait state. Each sample of 0 adds one further wait state.
- R6: Read data on tgt_din is captured at the rising edge that starts T3 and appears on host_rdata with the done pulse. A write transaction leaves host_rdata unchanged.
- R7: On writes, tgt_dout_oe is 1 from the falling edge of T1 to the end of T3, and tgt_dout carries the loaded write data. On reads, tgt_dout_oe stays 0.
- R8: With refresh enabled, two refresh states follow T3. rfsh_n is low in both, and rd_n, wr_n and iorq_n are 1. The address carries the 7-bit refresh count in its low bits, with zeros above. mreq_n is low from the falling edge of the first refresh state to the falling edge of the second. The count starts at 0 after reset and advances by one after each refresh phase.
- R9: host_busy is 1 from the host clock edge after an accepted start until host_done. host_done is 1 for exactly one host clock cycle.
- R10: After the last state of a transaction, every strobe returns to 1 and both output enables return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| host_start | input | 1 | Start strobe, one host clock wide |
| host_addr | input | ADDR_W | Address for the transaction |
| host_wdata | input | DATA_W | Data for write transactions |
| host_write | input | 1 | 1 = write, 0 = read |
| host_io | input | 1 | 1 = I/O space, 0 = memory space |
| host_refresh | input | 1 | 1 = append a refresh phase |
| host_busy | output | 1 | Transaction in flight |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Data captured by the last read |
| tgt_clk | input | 1 | Clock supplied to the processor socket |
| tgt_wait_n | input | 1 | Active-low wait request from the target |
| tgt_din | input | DATA_W | Data bus as seen from the socket |
| tgt_addr | output | ADDR_W | Address bus value |
| tgt_addr_oe | output | 1 | Address bus drive enable |
| tgt_dout | output | DATA_W | Data bus value for writes |
| tgt_dout_oe | output | 1 | Data bus drive enable |
| tgt_mreq_n | output | 1 | Memory request strobe |
| tgt_iorq_n | output | 1 | I/O request strobe |
| tgt_rd_n | output | 1 | Read strobe |
| tgt_wr_n | output | 1 | Write strobe |
| tgt_rfsh_n | output | 1 | Refresh strobe |

## Verification
The bench builds the block with its defaults: a 16-bit address, 8-bit data, a 7-bit refresh count, a two-stage synchroniser chain and the refresh variant present. That makes the full address width and the refresh phase reachable. The refresh count can be followed across several refresh transactions and seen on the low address bits. With the two clocks unrelated and four host cycles per target cycle, the wait-state paths for both memory and I/O can be stretched to several extra states. The capture of read data can then be tied to a single rising edge.

// File: rtl/bcg_pkg.sv
`timescale 1ns/1ps
package bcg_pkg;
   // T-state of the socket-side sequencer
   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_T1   = 3'd1,
      S_T2   = 3'd2,
      S_TW   = 3'd3,
      S_T3   = 3'd4,
      S_R3   = 3'd5,
      S_R4   = 3'd6
   } tstate_e;
endpackage

// File: rtl/bcg_sync.sv
`timescale 1ns/1ps
module bcg_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("bcg_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bcg_host_if.sv
`timescale 1ns/1ps
module bcg_host_if #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              sys_clk,
   input  logic              rst_n,
   input  logic              host_start,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_write,
   input  logic              host_io,
   input  logic              host_refresh,
   output logic              host_busy,
   output logic              host_done,
   output logic [DATA_W-1:0] host_rdata,
   // towards the target domain
   output logic              req_tgl,
   output logic [ADDR_W-1:0] hold_addr,
   output logic [DATA_W-1:0] hold_wdata,
   output logic              hold_write,
   output logic              hold_io,
   output logic              hold_refresh,
   // back from the target domain
   input  logic              ack_tgl,
   input  logic [DATA_W-1:0] ret_data
);
   logic ack_s;
   logic ack_seen;
   logic ack_edge;
   logic accept;

   bcg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (sys_clk),
      .rst_n (rst_n),
      .d     (ack_tgl),
      .q     (ack_s)
   );

   assign ack_edge = ack_s ^ ack_seen;
   assign accept   = host_start & ~host_busy;

   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_tgl      <= 1'b0;
         ack_seen     <= 1'b0;
         host_busy    <= 1'b0;
         host_done    <= 1'b0;
         host_rdata   <= '0;
         hold_addr    <= '0;
         hold_wdata   <= '0;
         hold_write   <= 1'b0;
         hold_io      <= 1'b0;
         hold_refresh <= 1'b0;
      end else begin
         host_done <= 1'b0;
         if (accept) begin
            hold_addr    <= host_addr;
            hold_wdata   <= host_wdata;
            hold_write   <= host_write;
            hold_io      <= host_io;
            hold_refresh <= host_refresh;
            req_tgl      <= ~req_tgl;
            host_busy    <= 1'b1;
         end else if (host_busy && ack_edge) begin
            ack_seen  <= ack_s;
            host_busy <= 1'b0;
            host_done <= 1'b1;
            if (!hold_write) host_rdata <= ret_data;
         end
      end
   end

   // R2: a start seen while busy must not launch a second request
   a_r2_busy_ignores_start: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (host_busy && host_start) |=> $stable(req_tgl));

   // R9: done lasts one host cycle
   a_r9_done_single: assert property (@(posedge sys_clk) disable iff (!rst_n)
      host_done |=> !host_done);

   // R9: done ends the busy interval
   a_r9_done_clears_busy: assert property (@(posedge sys_clk) disable iff (!rst_n)
      host_done |-> !host_busy);
endmodule

// File: rtl/bcg_strobes.sv
`timescale 1ns/1ps
module bcg_strobes
   import bcg_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int REF_W  = 7
) (
   input  tstate_e           st,        // state updated on rising edges
   input  tstate_e           st_fall,   // state seen at the last falling edge
   input  logic              c_write,
   input  logic              c_io,
   input  logic [ADDR_W-1:0] c_addr,
   input  logic [DATA_W-1:0] c_wdata,
   input  logic [REF_W-1:0]  ref_cnt,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic              tgt_addr_oe,
   output logic [DATA_W-1:0] tgt_dout,
   output logic              tgt_dout_oe,
   output logic              tgt_mreq_n,
   output logic              tgt_iorq_n,
   output logic              tgt_rd_n,
   output logic              tgt_wr_n,
   output logic              tgt_rfsh_n
);
   localparam int PAD_W = ADDR_W - REF_W;

   logic in_refresh;
   logic mem_win;     // falling T1 .. falling T3
   logic mem_wr_win;  // falling T2 .. falling T3
   logic io_win;      // rising T2 .. falling T3
   logic ref_pulse;   // falling R3 .. falling R4
   logic data_win;

   always_comb begin
      in_refresh = (st == S_R3) || (st == S_R4);
      mem_win    = (st_fall == S_T1) || (st_fall == S_T2) || (st_fall == S_TW);
      mem_wr_win = (st_fall == S_T2) || (st_fall == S_TW);
      io_win     = ((st == S_T2) || (st == S_TW) || (st == S_T3)) && (st_fall != S_T3);
      ref_pulse  = (st_fall == S_R3);
      data_win   = ((st == S_T1) && (st_fall == S_T1)) ||
                   (st == S_T2) || (st == S_TW) || (st == S_T3);
   end

   always_comb begin
      tgt_mreq_n  = ~((~c_io & mem_win) | ref_pulse);
      tgt_iorq_n  = ~(c_io & io_win);
      tgt_rd_n    = ~(~c_write & (c_io ? io_win : mem_win));
      tgt_wr_n    = ~(c_write & (c_io ? io_win : mem_wr_win));
      tgt_rfsh_n  = ~in_refresh;
      tgt_addr_oe = (st != S_IDLE);
      tgt_addr    = in_refresh ? {{PAD_W{1'b0}}, ref_cnt} : c_addr;
      tgt_dout_oe = c_write & data_win;
      tgt_dout    = c_wdata;
   end
endmodule

// File: rtl/bcg_seq.sv
`timescale 1ns/1ps
module bcg_seq
   import bcg_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int REF_W       = 7,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_REFRESH = 1'b1
) (
   input  logic              tgt_clk,
   input  logic              rst_n,
   input  logic              req_tgl,
   input  logic [ADDR_W-1:0] hold_addr,
   input  logic [DATA_W-1:0] hold_wdata,
   input  logic              hold_write,
   input  logic              hold_io,
   input  logic              hold_refresh,
   output logic              ack_tgl,
   output logic [DATA_W-1:0] ret_data,
   input  logic              tgt_wait_n,
   input  logic [DATA_W-1:0] tgt_din,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic              tgt_addr_oe,
   output logic [DATA_W-1:0] tgt_dout,
   output logic              tgt_dout_oe,
   output logic              tgt_mreq_n,
   output logic              tgt_iorq_n,
   output logic              tgt_rd_n,
   output logic              tgt_wr_n,
   output logic              tgt_rfsh_n
);
   tstate_e st, st_nx, st_fall;
   logic    req_s, req_seen;
   logic    wait_q;
   logic    ref_ok;
   logic [REF_W-1:0]  ref_cnt;
   logic [ADDR_W-1:0] c_addr;
   logic [DATA_W-1:0] c_wdata;
   logic              c_write, c_io, c_ref;

   bcg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (tgt_clk),
      .rst_n (rst_n),
      .d     (req_tgl),
      .q     (req_s)
   );

   // next T-state on the coming rising edge
   always_comb begin
      st_nx = st;
      unique case (st)
         S_IDLE: if (req_s != req_seen) st_nx = S_T1;
         S_T1:   st_nx = S_T2;
         S_T2:   st_nx = (c_io || !wait_q) ? S_TW : S_T3;
         S_TW:   st_nx = wait_q ? S_T3 : S_TW;
         S_T3:   st_nx = c_ref ? S_R3 : S_IDLE;
         S_R3:   st_nx = S_R4;
         S_R4:   st_nx = S_IDLE;
         default: st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge tgt_clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         req_seen <= 1'b0;
         ack_tgl  <= 1'b0;
         ret_data <= '0;
         c_addr   <= '0;
         c_wdata  <= '0;
         c_write  <= 1'b0;
         c_io     <= 1'b0;
         c_ref    <= 1'b0;
      end else begin
         st <= st_nx;
         if (st == S_IDLE && st_nx == S_T1) begin
            req_seen <= req_s;
            c_addr   <= hold_addr;
            c_wdata  <= hold_wdata;
            c_write  <= hold_write;
            c_io     <= hold_io;
            c_ref    <= hold_refresh & ref_ok;
         end
         if (!c_write && st != S_T3 && st_nx == S_T3) ret_data <= tgt_din;
         if (st != S_IDLE && st_nx == S_IDLE) ack_tgl <= ~ack_tgl;
      end
   end

   // falling-edge view: state and the wait sample
   always_ff @(negedge tgt_clk or negedge rst_n) begin
      if (!rst_n) begin
         st_fall <= S_IDLE;
         wait_q  <= 1'b1;
      end else begin
         st_fall <= st;
         wait_q  <= tgt_wait_n;
      end
   end

   generate
      if (HAS_REFRESH) begin : g_refresh
         if (REF_W >= ADDR_W) begin : g_bad_ref
            $error("refresh count must be narrower than the address");
         end
         logic [REF_W-1:0] cnt_q;
         always_ff @(posedge tgt_clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (st == S_R4)   cnt_q <= cnt_q + 1'b1;
         end
         assign ref_cnt = cnt_q;
         assign ref_ok  = 1'b1;
      end else begin : g_no_refresh
         assign ref_cnt = '0;
         assign ref_ok  = 1'b0;
      end
   endgenerate

   bcg_strobes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REF_W(REF_W)) u_strobes (
      .st          (st),
      .st_fall     (st_fall),
      .c_write     (c_write),
      .c_io        (c_io),
      .c_addr      (c_addr),
      .c_wdata     (c_wdata),
      .ref_cnt     (ref_cnt),
      .tgt_addr    (tgt_addr),
      .tgt_addr_oe (tgt_addr_oe),
      .tgt_dout    (tgt_dout),
      .tgt_dout_oe (tgt_dout_oe),
      .tgt_mreq_n  (tgt_mreq_n),
      .tgt_iorq_n  (tgt_iorq_n),
      .tgt_rd_n    (tgt_rd_n),
      .tgt_wr_n    (tgt_wr_n),
      .tgt_rfsh_n  (tgt_rfsh_n)
   );

   // R4: the two request strobes are never low together
   a_r4_one_request: assert property (@(posedge tgt_clk) disable iff (!rst_n)
      !(!tgt_mreq_n && !tgt_iorq_n));

   // R3: read and write strobes are exclusive
   a_r3_rd_wr_exclusive: assert property (@(posedge tgt_clk) disable iff (!rst_n)
      !(!tgt_rd_n && !tgt_wr_n));

   // R8: no transfer strobe during refresh
   a_r8_refresh_quiet: assert property (@(posedge tgt_clk) disable iff (!rst_n)
      !tgt_rfsh_n |-> (tgt_rd_n && tgt_wr_n && tgt_iorq_n));

   // R5: a low wait sample in a wait state keeps the wait state
   a_r5_wait_holds: assert property (@(posedge tgt_clk) disable iff (!rst_n)
      (st == S_TW && !wait_q) |=> (st == S_TW));

   // R2: a transaction only begins from idle
   a_r2_t1_from_idle: assert property (@(posedge tgt_clk) disable iff (!rst_n)
      (st == S_T1) |-> ($past(st) == S_IDLE));

   // R10: released pins while idle
   a_r10_idle_released: assert property (@(posedge tgt_clk) disable iff (!rst_n)
      (st == S_IDLE) |-> (!tgt_addr_oe && !tgt_dout_oe && tgt_mreq_n && tgt_iorq_n
                          && tgt_rd_n && tgt_wr_n && tgt_rfsh_n));
endmodule

// File: rtl/bus_cycle_gen.sv
`timescale 1ns/1ps
module bus_cycle_gen #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int REF_W       = 7,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_REFRESH = 1'b1
) (
   input  logic              sys_clk,
   input  logic              rst_n,
   input  logic              host_start,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_write,
   input  logic              host_io,
   input  logic              host_refresh,
   output logic              host_busy,
   output logic              host_done,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              tgt_clk,
   input  logic              tgt_wait_n,
   input  logic [DATA_W-1:0] tgt_din,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic              tgt_addr_oe,
   output logic [DATA_W-1:0] tgt_dout,
   output logic              tgt_dout_oe,
   output logic              tgt_mreq_n,
   output logic              tgt_iorq_n,
   output logic              tgt_rd_n,
   output logic              tgt_wr_n,
   output logic              tgt_rfsh_n
);
   generate
      if (ADDR_W < 8 || DATA_W < 1) begin : g_bad_width
         $error("bus_cycle_gen: address or data width too small");
      end
   endgenerate

   logic              req_tgl, ack_tgl;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_wdata, ret_data;
   logic              hold_write, hold_io, hold_refresh;

   bcg_host_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_host (
      .sys_clk      (sys_clk),
      .rst_n        (rst_n),
      .host_start   (host_start),
      .host_addr    (host_addr),
      .host_wdata   (host_wdata),
      .host_write   (host_write),
      .host_io      (host_io),
      .host_refresh (host_refresh),
      .host_busy    (host_busy),
      .host_done    (host_done),
      .host_rdata   (host_rdata),
      .req_tgl      (req_tgl),
      .hold_addr    (hold_addr),
      .hold_wdata   (hold_wdata),
      .hold_write   (hold_write),
      .hold_io      (hold_io),
      .hold_refresh (hold_refresh),
      .ack_tgl      (ack_tgl),
      .ret_data     (ret_data)
   );

   bcg_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REF_W(REF_W),
             .SYNC_STAGES(SYNC_STAGES), .HAS_REFRESH(HAS_REFRESH)) u_seq (
      .tgt_clk      (tgt_clk),
      .rst_n        (rst_n),
      .req_tgl      (req_tgl),
      .hold_addr    (hold_addr),
      .hold_wdata   (hold_wdata),
      .hold_write   (hold_write),
      .hold_io      (hold_io),
      .hold_refresh (hold_refresh),
      .ack_tgl      (ack_tgl),
      .ret_data     (ret_data),
      .tgt_wait_n   (tgt_wait_n),
      .tgt_din      (tgt_din),
      .tgt_addr     (tgt_addr),
      .tgt_addr_oe  (tgt_addr_oe),
      .tgt_dout     (tgt_dout),
      .tgt_dout_oe  (tgt_dout_oe),
      .tgt_mreq_n   (tgt_mreq_n),
      .tgt_iorq_n   (tgt_iorq_n),
      .tgt_rd_n     (tgt_rd_n),
      .tgt_wr_n     (tgt_wr_n),
      .tgt_rfsh_n   (tgt_rfsh_n)
   );
endmodule

// File: tb/bus_cycle_gen_test.sv
`timescale 1ns/1ps
module bus_cycle_gen_test;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 8;
   localparam int NV     = 8;

   // vector fields: [36:21] addr, [20:13] wdata, [12:5] din,
   // [4] write, [3] io, [2] refresh, [1:0] extra wait samples
   localparam logic [36:0] VECS [NV] = '{
      {16'h1234, 8'h00, 8'hA5, 1'b0, 1'b0, 1'b0, 2'd0},
      {16'hBEEF, 8'h3C, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0},
      {16'h0042, 8'h00, 8'h5A, 1'b0, 1'b1, 1'b0, 2'd0},
      {16'h00F0, 8'hC3, 8'h00, 1'b1, 1'b1, 1'b0, 2'd2},
      {16'h8001, 8'h00, 8'h7E, 1'b0, 1'b0, 1'b1, 2'd1},
      {16'h4000, 8'h99, 8'h00, 1'b1, 1'b0, 1'b1, 2'd3},
      {16'h0011, 8'h00, 8'h01, 1'b0, 1'b1, 1'b1, 2'd1},
      {16'hFFFF, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b1, 2'd0}
   };

   localparam int ST_T1 = 1, ST_T2 = 2, ST_TW = 3, ST_T3 = 4, ST_R3 = 5, ST_R4 = 6;

   logic              sys_clk = 1'b0;
   logic              tgt_clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_start = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic [DATA_W-1:0] host_wdata = '0;
   logic              host_write = 1'b0, host_io = 1'b0, host_refresh = 1'b0;
   logic              host_busy, host_done;
   logic [DATA_W-1:0] host_rdata;
   logic              tgt_wait_n = 1'b1;
   logic [DATA_W-1:0] tgt_din = '0;
   logic [ADDR_W-1:0] tgt_addr;
   logic              tgt_addr_oe;
   logic [DATA_W-1:0] tgt_dout;
   logic              tgt_dout_oe;
   logic              tgt_mreq_n, tgt_iorq_n, tgt_rd_n, tgt_wr_n, tgt_rfsh_n;

   int  checks = 0;
   int  errors = 0;
   int  cyc_cnt = 0;
   int  cyc_exp = 0;
   int  ref_exp = 0;
   logic [DATA_W-1:0] rdata_exp = '0;
   bit  finished = 1'b0;

   always #10 sys_clk = ~sys_clk;   // 50 MHz host clock
   always #40 tgt_clk = ~tgt_clk;   // slower, unrelated target clock

   always @(posedge tgt_addr_oe) cyc_cnt++;

   bus_cycle_gen uut (
      .sys_clk(sys_clk), .rst_n(rst_n), .host_start(host_start),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_write(host_write),
      .host_io(host_io), .host_refresh(host_refresh), .host_busy(host_busy),
      .host_done(host_done), .host_rdata(host_rdata), .tgt_clk(tgt_clk),
      .tgt_wait_n(tgt_wait_n), .tgt_din(tgt_din), .tgt_addr(tgt_addr),
      .tgt_addr_oe(tgt_addr_oe), .tgt_dout(tgt_dout), .tgt_dout_oe(tgt_dout_oe),
      .tgt_mreq_n(tgt_mreq_n), .tgt_iorq_n(tgt_iorq_n), .tgt_rd_n(tgt_rd_n),
      .tgt_wr_n(tgt_wr_n), .tgt_rfsh_n(tgt_rfsh_n)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [6:0] pins();
      return {tgt_mreq_n, tgt_iorq_n, tgt_rd_n, tgt_wr_n, tgt_rfsh_n, tgt_addr_oe, tgt_dout_oe};
   endfunction

   // watches the socket through one transaction, half T-state by half T-state
   task automatic observe(input logic [36:0] v);
      logic [ADDR_W-1:0] a  = v[36:21];
      logic [DATA_W-1:0] wd = v[20:13];
      logic [DATA_W-1:0] dn = v[12:5];
      bit wr = v[4], io = v[3], rf = v[2];
      int ntw = int'(io) + int'(v[1:0]);
      int nst = 3 + ntw + (rf ? 2 : 0);
      tgt_din = ~dn;
      @(posedge tgt_addr_oe);
      #25;
      for (int k = 0; k < 2 * nst; k++) begin
         int idx = k / 2;
         bit ph  = (k % 2) == 1;
         int s;
         bit mem_win, io_win, mw_win, rp, emq, eio, erd, ewr, erf, edo;
         logic [6:0] exp;
         logic [ADDR_W-1:0] ea;
         string tag;
         if (idx == 0)             s = ST_T1;
         else if (idx == 1)        s = ST_T2;
         else if (idx < 2 + ntw)   s = ST_TW;
         else if (idx == 2 + ntw)  s = ST_T3;
         else if (idx == 3 + ntw)  s = ST_R3;
         else                      s = ST_R4;
         mem_win = (s == ST_T1 && ph) || s == ST_T2 || s == ST_TW || (s == ST_T3 && !ph);
         io_win  = s == ST_T2 || s == ST_TW || (s == ST_T3 && !ph);
         mw_win  = (s == ST_T2 && ph) || s == ST_TW || (s == ST_T3 && !ph);
         rp      = (s == ST_R3 && ph) || (s == ST_R4 && !ph);
         emq = !((!io && mem_win) || rp);
         eio = !(io && io_win);
         erd = !(!wr && (io ? io_win : mem_win));
         ewr = !(wr && (io ? io_win : mw_win));
         erf = !(s == ST_R3 || s == ST_R4);
         edo = wr && ((s == ST_T1 && ph) || s == ST_T2 || s == ST_TW || s == ST_T3);
         exp = {emq, eio, erd, ewr, erf, 1'b1, edo};
         if (s == ST_R3 || s == ST_R4) tag = "R8";
         else if (s == ST_TW)          tag = "R5";
         else if (io)                  tag = "R4";
         else                          tag = "R3";
         chk(pins() == exp, tag, "strobes {mreq,iorq,rd,wr,rfsh,aoe,doe}",
             32'(pins()), 32'(exp));
         ea = (s == ST_R3 || s == ST_R4) ? ADDR_W'(ref_exp[6:0]) : a;
         chk(tgt_addr == ea, (s >= ST_R3) ? "R8" : "R3", "address", 32'(tgt_addr), 32'(ea));
         if (edo) chk(tgt_dout == wd, "R7", "write data", 32'(tgt_dout), 32'(wd));
         // wait input for the falling edge that opens half k+1
         if (!ph) tgt_wait_n = !((k + 1) >= 3 && (k + 1) <= 2 * ntw + 1);
         // read data valid only around the rising edge that opens T3
         if (k == 2 * (2 + ntw) - 1) tgt_din = dn;
         if (k == 2 * (2 + ntw) + 1) tgt_din = ~dn;
         #40;
      end
      chk(pins() == 7'b1111100, "R10", "pins after transaction",
          32'(pins()), 32'h7C);
      tgt_wait_n = 1'b1;
      if (rf) ref_exp = (ref_exp + 1) % 128;
   endtask

   task automatic host_run(input logic [36:0] v, input bit poke);
      bit seen = 1'b0;
      @(negedge sys_clk);
      host_addr = v[36:21]; host_wdata = v[20:13];
      host_write = v[4]; host_io = v[3]; host_refresh = v[2];
      host_start = 1'b1;
      @(negedge sys_clk);
      host_start = 1'b0;
      chk(host_busy == 1'b1, "R9", "busy after start", 32'(host_busy), 32'd1);
      if (poke) begin
         @(negedge sys_clk);
         host_addr = 16'h5555; host_write = ~v[4]; host_io = ~v[3];
         host_start = 1'b1;
         @(negedge sys_clk);
         host_start = 1'b0;
      end
      for (int i = 0; i < 2000 && !seen; i++) begin
         @(negedge sys_clk);
         if (host_done) seen = 1'b1;
      end
      chk(seen, "R9", "done pulse seen", 32'(seen), 32'd1);
      if (!v[4]) rdata_exp = v[12:5];
      chk(host_rdata == rdata_exp, "R6", "host read data", 32'(host_rdata), 32'(rdata_exp));
      @(negedge sys_clk);
      chk(host_done == 1'b0 && host_busy == 1'b0, "R9", "done one cycle then idle",
          32'({host_done, host_busy}), 32'd0);
   endtask

   task automatic run_vec(input logic [36:0] v, input bit poke);
      fork
         observe(v);
         host_run(v, poke);
      join
      cyc_exp++;
      if (poke) #3200;
      chk(cyc_cnt == cyc_exp, "R2", "transaction count", 32'(cyc_cnt), 32'(cyc_exp));
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state, during and after reset
      #95;
      chk(pins() == 7'b1111100, "R1", "pins in reset", 32'(pins()), 32'h7C);
      chk({host_busy, host_done} == 2'b00, "R1", "host flags in reset",
          32'({host_busy, host_done}), 32'd0);
      rst_n = 1'b1;
      #400;
      chk(pins() == 7'b1111100, "R1", "pins after reset", 32'(pins()), 32'h7C);
      chk(host_rdata == '0, "R1", "read data after reset", 32'(host_rdata), 32'd0);

      // table walk: memory/I/O, read/write, waits, refresh
      for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

      // R2: start while busy is ignored; the running transaction keeps its fields
      run_vec({16'h2468, 8'h00, 8'h6D, 1'b0, 1'b0, 1'b1, 2'd2}, 1'b1);
      // R6: write after read leaves host read data unchanged
      run_vec({16'h1357, 8'hE1, 8'h00, 1'b1, 1'b1, 1'b0, 2'd0}, 1'b0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule